// File: doc/BRIEF.md
# SPI Clock and Chip-Select Timing Sequencer

This block produces the serial clock and the active-low chip-select of an SPI master. A one-cycle start pulse begins a burst of a given number of bits. Every phase of the waveform has its own length, counted in ticks of the input clock and encoded as a count minus one. The phases are the chip-select setup gap, the SCK high and low phases, the chip-select hold gap and the minimum chip-select idle gap. Clock polarity and clock phase are taken per burst.

The block does not move data. It gives a separate shift register one-cycle launch and sample strobes, aligned to the SCK edges that the selected clock phase calls for. It raises a done pulse at the end of a burst. With the keep-CS input set, chip-select stays asserted across bursts, so a transfer can be paused and resumed without releasing the slave.

Top module: `spi_timing_seq`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0, and launch_o, sample_o and done_o are 0.
- R2: The timing word carries clock-high in bits 7:0, clock-low in bits 15:8, CS-hold in bits 23:16 and CS-setup in bits 31:24. The first SCK edge is seen setup+1 cycles after cs_n_o first reads low.
- R3: SCK stays high for high+1 cycles and low for low+1 cycles. A burst of N bits makes exactly 2N SCK edges, and no minimum-length phase lasts less than one cycle.
- R4: Without keep-CS, cs_n_o rises hold+1 cycles after the last SCK edge. done_o pulses for exactly one cycle, in the same cycle as that rise.
- R5: After cs_n_o rises, it stays high for at least idle+1 cycles. With start held high, it falls again exactly idle+2 cycles after it rose.
- R6: SCK rests at the CPOL level (0 or 1) whenever no burst runs. With cs_n_o high and the block idle, it follows cpol_i one cycle later.
- R7: With CPHA=0, sample strobes follow each leading SCK edge. Launch strobes come with the chip-select assertion cycle and with each trailing edge except the last. With CPHA=1, launch strobes follow leading edges and sample strobes follow trailing edges. Each burst gives N of each, and each strobe appears in the same cycle as the new SCK level, or the new chip-select level. Strobes occur only while cs_n_o is low.
- R8: launch_o and sample_o are never high in the same cycle.
- R9: The timing word, idle field, CPOL, CPHA and bit count are taken on the accepted start. Changes during a burst do not alter it.
- R10: If keep_cs_i is 1 at the last trailing edge, cs_n_o stays low and done_o pulses in the cycle that shows that edge. The next start then runs its setup gap and bits without cs_n_o going high.
- R11: A start pulse is ignored while a burst, its hold gap or its idle gap is in progress, and a start with a bit count of 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst (taken only when idle) |
| keep_cs_i | input | 1 | Leave chip-select asserted at the end of the burst |
| bit_count_i | input | BIT_W | Number of bits in the burst |
| cpol_i | input | 1 | Clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| timing_cfg_i | input | 32 | {setup, hold, low, high}, each count minus one |
| idle_cfg_i | input | 8 | Minimum chip-select high gap, count minus one |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip-select |
| launch_o | output | 1 | One-cycle strobe to shift out the next bit |
| sample_o | output | 1 | One-cycle strobe to capture the incoming bit |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
The done pulse and the chip-select rise fall in the same cycle when a burst ends, and the bench judges both against one computed cycle. A start already waiting can land in the first idle cycle after the idle gap. The bench provokes this by holding start high from the done cycle onward, and checks that chip-select falls again exactly idle+2 cycles after it rose. With minimum fields, a launch or sample strobe can fall in the cycle right after the chip-select assertion strobe. The bench checks each strobe position and relies on the exclusion check to show the two never merge.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int FIELD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_REST,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [FIELD_W-1:0] setup;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] low;
        logic [FIELD_W-1:0] high;
        logic [FIELD_W-1:0] idle;
        logic               cpol;
        logic               cpha;
    } seq_cfg_t;

    function automatic seq_cfg_t unpack_cfg(input logic [4*FIELD_W-1:0] word,
                                            input logic [FIELD_W-1:0]   idle,
                                            input logic                 cpol,
                                            input logic                 cpha);
        seq_cfg_t c;
        c.high  = word[FIELD_W-1:0];
        c.low   = word[2*FIELD_W-1:FIELD_W];
        c.hold  = word[3*FIELD_W-1:2*FIELD_W];
        c.setup = word[4*FIELD_W-1:3*FIELD_W];
        c.idle  = idle;
        c.cpol  = cpol;
        c.cpha  = cpha;
        return c;
    endfunction

endpackage

// File: rtl/spi_seq_down_ctr.sv
module spi_seq_down_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         dec_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (dec_i && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R3
    ctr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/spi_seq_cfg_reg.sv
module spi_seq_cfg_reg
    import spi_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture_i,
    input  seq_cfg_t cfg_i,
    output seq_cfg_t cfg_o
);
    seq_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (capture_i) cfg_d = cfg_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/spi_timing_seq.sv
module spi_timing_seq
    import spi_seq_pkg::*;
#(
    parameter int BIT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 keep_cs_i,
    input  logic [BIT_W-1:0]     bit_count_i,
    input  logic                 cpol_i,
    input  logic                 cpha_i,
    input  logic [4*FIELD_W-1:0] timing_cfg_i,
    input  logic [FIELD_W-1:0]   idle_cfg_i,
    output logic                 sck_o,
    output logic                 cs_n_o,
    output logic                 launch_o,
    output logic                 sample_o,
    output logic                 done_o
);
    typedef struct packed {
        seq_state_e st;
        logic       cs_n;
        logic       sck;
        logic       launch;
        logic       sample;
        logic       done;
    } seq_regs_t;

    seq_regs_t          r_d, r_q;
    seq_cfg_t           cfg_live, cfg_q;
    logic               accept;
    logic               tick_load, tick_zero;
    logic [FIELD_W-1:0] tick_val;
    logic               bit_load, bit_dec, bit_zero;
    logic [FIELD_W-1:0] act_len, rest_len;

    assign cfg_live = unpack_cfg(timing_cfg_i, idle_cfg_i, cpol_i, cpha_i);
    assign accept   = (r_q.st == ST_IDLE) && start_i && (bit_count_i != '0);
    assign act_len  = cfg_q.cpol ? cfg_q.low  : cfg_q.high;
    assign rest_len = cfg_q.cpol ? cfg_q.high : cfg_q.low;

    spi_seq_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (accept),
        .cfg_i     (cfg_live),
        .cfg_o     (cfg_q)
    );

    spi_seq_down_ctr #(.W(FIELD_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tick_load),
        .dec_i  (1'b1),
        .val_i  (tick_val),
        .zero_o (tick_zero)
    );

    spi_seq_down_ctr #(.W(BIT_W)) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (bit_load),
        .dec_i  (bit_dec),
        .val_i  (bit_count_i - 1'b1),
        .zero_o (bit_zero)
    );

    always_comb begin
        r_d       = r_q;
        r_d.launch = 1'b0;
        r_d.sample = 1'b0;
        r_d.done   = 1'b0;
        tick_load = 1'b0;
        tick_val  = '0;
        bit_load  = 1'b0;
        bit_dec   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (r_q.cs_n) r_d.sck = cpol_i;
                if (accept) begin
                    r_d.st     = ST_SETUP;
                    r_d.cs_n   = 1'b0;
                    r_d.launch = !cpha_i;
                    tick_load  = 1'b1;
                    tick_val   = cfg_live.setup;
                    bit_load   = 1'b1;
                end
            end
            ST_SETUP, ST_REST: begin
                if (tick_zero) begin
                    r_d.st     = ST_ACTIVE;
                    r_d.sck    = !cfg_q.cpol;
                    r_d.sample = !cfg_q.cpha;
                    r_d.launch = cfg_q.cpha;
                    tick_load  = 1'b1;
                    tick_val   = act_len;
                end
            end
            ST_ACTIVE: begin
                if (tick_zero) begin
                    r_d.sck    = cfg_q.cpol;
                    r_d.sample = cfg_q.cpha;
                    r_d.launch = !cfg_q.cpha && !bit_zero;
                    if (!bit_zero) begin
                        r_d.st    = ST_REST;
                        tick_load = 1'b1;
                        tick_val  = rest_len;
                        bit_dec   = 1'b1;
                    end else if (keep_cs_i) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st    = ST_HOLD;
                        tick_load = 1'b1;
                        tick_val  = cfg_q.hold;
                    end
                end
            end
            ST_HOLD: begin
                if (tick_zero) begin
                    r_d.st    = ST_GAP;
                    r_d.cs_n  = 1'b1;
                    r_d.done  = 1'b1;
                    tick_load = 1'b1;
                    tick_val  = cfg_q.idle;
                end
            end
            ST_GAP: begin
                if (tick_zero) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.cs_n   <= 1'b1;
            r_q.sck    <= 1'b0;
            r_q.launch <= 1'b0;
            r_q.sample <= 1'b0;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck_o    = r_q.sck;
    assign cs_n_o   = r_q.cs_n;
    assign launch_o = r_q.launch;
    assign sample_o = r_q.sample;
    assign done_o   = r_q.done;

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.launch && r_q.sample));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R7
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.launch || r_q.sample) |-> !r_q.cs_n);

    // R6
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cs_n && r_q.st != ST_IDLE) |-> (r_q.sck == cfg_q.cpol));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> $stable(cfg_q));

endmodule

// File: tb/spi_timing_seq_tb_top.sv
module spi_timing_seq_tb_top;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          keep_cs_i = 1'b0;
    logic [BW-1:0] bit_count_i = '0;
    logic          cpol_i = 1'b0;
    logic          cpha_i = 1'b0;
    logic [31:0]   timing_cfg_i = '0;
    logic [7:0]    idle_cfg_i = '0;
    logic          sck_o, cs_n_o, launch_o, sample_o, done_o;

    spi_timing_seq #(.BIT_W(BW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .keep_cs_i    (keep_cs_i),
        .bit_count_i  (bit_count_i),
        .cpol_i       (cpol_i),
        .cpha_i       (cpha_i),
        .timing_cfg_i (timing_cfg_i),
        .idle_cfg_i   (idle_cfg_i),
        .sck_o        (sck_o),
        .cs_n_o       (cs_n_o),
        .launch_o     (launch_o),
        .sample_o     (sample_o),
        .done_o       (done_o)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit mon_en = 1'b0;
    logic p_sck, p_cs;
    int edg[256], lt[256], smp[256];
    int n_edge, n_l, n_s, n_done, n_fall, n_rise, done_t, rise_t, c0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (p_cs && !cs_n_o) n_fall++;
            if (!p_cs && cs_n_o) begin n_rise++; rise_t = cyc; end
            if (sck_o != p_sck && n_edge < 256) begin edg[n_edge] = cyc; n_edge++; end
            if (launch_o && n_l < 256) begin lt[n_l] = cyc; n_l++; end
            if (sample_o && n_s < 256) begin smp[n_s] = cyc; n_s++; end
            if (done_o) begin n_done++; done_t = cyc; end
        end
        p_sck = sck_o;
        p_cs  = cs_n_o;
    end

    task automatic chk_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_edge = 0; n_l = 0; n_s = 0; n_done = 0;
        n_fall = 0; n_rise = 0; done_t = -1; rise_t = -1;
    endtask

    task automatic launch(int n, bit pol, bit pha, logic [31:0] cfg,
                          logic [7:0] idl, bit keep);
        @(negedge clk);
        bit_count_i = n[BW-1:0]; cpol_i = pol; cpha_i = pha;
        timing_cfg_i = cfg; idle_cfg_i = idl; keep_cs_i = keep;
        repeat (2) @(negedge clk);
        clear_mon();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        c0 = cyc;
    endtask

    task automatic wait_done();
        int w = 0;
        while (n_done == 0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 5000) chk_eq("R4 done never seen", 0, 1);
    endtask

    task automatic check_burst(int n, bit pol, bit pha, logic [31:0] cfg, bit keep);
        int a, r, s, h, lk, tk, tl;
        a = pol ? int'(cfg[15:8]) : int'(cfg[7:0]);
        r = pol ? int'(cfg[7:0])  : int'(cfg[15:8]);
        s = int'(cfg[31:24]);
        h = int'(cfg[23:16]);
        chk_eq("R3 edge count", n_edge, 2 * n);
        chk_eq("R2 first edge", edg[0], c0 + s + 1);
        chk_eq("R7 launch count", n_l, n);
        chk_eq("R7 sample count", n_s, n);
        tl = 0;
        for (int k = 0; k < n && 2 * k + 1 < 256; k++) begin
            lk = c0 + s + 1 + k * (a + r + 2);
            tk = lk + a + 1;
            tl = tk;
            chk_eq("R3 leading edge", edg[2 * k], lk);
            chk_eq("R3 trailing edge", edg[2 * k + 1], tk);
            if (!pha) begin
                chk_eq("R7 sample on leading", smp[k], lk);
                chk_eq("R7 launch", lt[k], (k == 0) ? c0 : lk - r - 1);
            end else begin
                chk_eq("R7 launch on leading", lt[k], lk);
                chk_eq("R7 sample on trailing", smp[k], tk);
            end
        end
        if (!keep) begin
            chk_eq("R4 cs rise", rise_t, tl + h + 1);
            chk_eq("R4 done cycle", done_t, tl + h + 1);
        end else begin
            chk_eq("R10 done at last edge", done_t, tl);
            chk_eq("R10 cs still low", int'(cs_n_o), 0);
            chk_eq("R10 no cs rise", n_rise, 0);
        end
        chk_eq("R4 single done", n_done, 1);
        chk_eq("R6 sck rest level", int'(sck_o), int'(pol));
    endtask

    task automatic t_reset();
        chk_eq("R1 cs_n", int'(cs_n_o), 1);
        chk_eq("R1 sck", int'(sck_o), 0);
        chk_eq("R1 strobes", int'(launch_o) + int'(sample_o) + int'(done_o), 0);
    endtask

    task automatic t_burst(int n, bit pol, bit pha, logic [31:0] cfg, logic [7:0] idl);
        launch(n, pol, pha, cfg, idl, 1'b0);
        wait_done();
        check_burst(n, pol, pha, cfg, 1'b0);
        repeat (int'(idl) + 4) @(negedge clk);
    endtask

    task automatic t_idle_follow();
        @(negedge clk); cpol_i = 1'b1;
        @(negedge clk);
        chk_eq("R6 idle sck follows cpol", int'(sck_o), 1);
        cpol_i = 1'b0;
        @(negedge clk);
        chk_eq("R6 idle sck follows cpol", int'(sck_o), 0);
    endtask

    task automatic t_cfg_change();
        logic [31:0] cfg = {8'd1, 8'd2, 8'd1, 8'd2};
        launch(3, 1'b0, 1'b0, cfg, 8'd2, 1'b0);
        repeat (2) @(negedge clk);
        timing_cfg_i = 32'hFFFF_FFFF; cpha_i = 1'b1; idle_cfg_i = 8'hFF;
        bit_count_i = 16'd9; start_i = 1'b1;     // R11 start while busy
        repeat (4) @(negedge clk);
        start_i = 1'b0; timing_cfg_i = cfg; cpha_i = 1'b0;
        wait_done();
        check_burst(3, 1'b0, 1'b0, cfg, 1'b0);   // R9
        idle_cfg_i = 8'd2;
        repeat (12) @(negedge clk);
        chk_eq("R11 no extra burst", n_fall, 1);
    endtask

    task automatic t_gap();
        int rt;
        logic [31:0] cfg = {8'd0, 8'd1, 8'd0, 8'd0};
        launch(1, 1'b0, 1'b0, cfg, 8'd5, 1'b0);
        while (!done_o) @(negedge clk);
        rt = cyc;
        start_i = 1'b1;
        chk_eq("R5 cs high at done", int'(cs_n_o), 1);
        while (cs_n_o) @(negedge clk);
        start_i = 1'b0;
        chk_eq("R5 idle gap", cyc - rt, 5 + 2);
        clear_mon();
        wait_done();
        repeat (10) @(negedge clk);
    endtask

    task automatic t_keep();
        logic [31:0] cfg = {8'd2, 8'd1, 8'd1, 8'd0};
        launch(2, 1'b0, 1'b1, cfg, 8'd1, 1'b1);
        wait_done();
        check_burst(2, 1'b0, 1'b1, cfg, 1'b1);
        repeat (3) @(negedge clk);
        chk_eq("R10 cs held between bursts", int'(cs_n_o), 0);
        launch(3, 1'b0, 1'b1, cfg, 8'd1, 1'b0);
        wait_done();
        check_burst(3, 1'b0, 1'b1, cfg, 1'b0);
        chk_eq("R10 no cs fall on resume", n_fall, 0);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_zero_bits();
        launch(0, 1'b0, 1'b0, 32'h0101_0101, 8'd1, 1'b0);
        repeat (20) @(negedge clk);
        chk_eq("R11 zero bits ignored cs", n_fall, 0);
        chk_eq("R11 zero bits ignored sck", n_edge, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements) act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        p_sck = sck_o; p_cs = cs_n_o;
        mon_en = 1'b1;
        t_idle_follow();
        t_burst(4, 1'b0, 1'b0, {8'd2, 8'd1, 8'd3, 8'd1}, 8'd3);
        t_burst(3, 1'b1, 1'b1, 32'h0000_0000, 8'd0);
        t_burst(5, 1'b0, 1'b1, {8'd5, 8'd3, 8'd1, 8'd4}, 8'd2);
        t_burst(2, 1'b1, 1'b0, {8'd1, 8'd2, 8'd3, 8'd0}, 8'd1);
        t_burst(40, 1'b0, 1'b0, {8'd0, 8'd0, 8'd0, 8'd1}, 8'd0);
        t_cfg_change();
        t_gap();
        t_keep();
        t_zero_bits();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule